// File: doc/BRIEF.md
# Address Translation and Protection Unit

This unit turns a 32-bit effective address into a 20-bit physical page number and an access verdict, for one request per strobe. Every request carries its own attributes: instruction or data, read or write, supervisor or user, and translation on or off. The unit resolves the address along a fixed order. With translation off the address passes through. When the selected segment is marked as direct-store, the access is either memory-forced or rejected. Otherwise the block-translation entries of the request's side are searched. When all of these fail, the unit asks for a hashed-table walk. It does not perform that walk; it only raises the request.

Sixteen segment registers and eight block-translation entries are loaded through a small synchronous write port. Entries 0 to 3 serve instruction fetches and entries 4 to 7 serve data accesses. A block entry takes three write words. Protection is decided by a 16-way rule indexed by the write flag, the selected key and the two pp bits. The result, with a fault status word, is registered one clock after the request strobe.

Top module: `xlat_unit`

## Requirements
- R1: Reset (synchronous, `rst` high) clears all segment and block-entry state so that no entry is usable, and holds `res_valid` low. After reset, a translated access whose segment has bit 31 clear reports a walk.
- R2: With `req_xlate_en` low, `res_ppn` is `req_ea[31:12]` and `res_attr` is 0xC2. No access is ever a violation in this case, writes included. The attribute layout is [7] referenced, [6] changed, [5:2] wimg, [1:0] pp.
- R3: The segment register is chosen by `req_ea[31:28]`; config addresses 0..15 hold segments 0..15. If the segment has bit 31 set and its bits 28:20 equal 0x7F, the access is memory-forced: `res_ppn` = {segment[3:0], `req_ea[27:12]`}, `res_attr` = 0xC2, status 0.
- R4: If the segment has bit 31 set and its bits 28:20 are not 0x7F, `res_dserr` is 1. In that case `res_walk` is 0, `res_ppn`, `res_attr` and `res_status` are 0.
- R5: Instruction requests (`req_data`=0) search only entries 0..3; data requests search only entries 4..7.
- R6: An entry covers a page when base <= page <= base+size-1, a size of 0 covering nothing. Among covering usable entries, the lowest-numbered one wins.
- R7: An entry is usable only when its valid bit is set and, in supervisor mode, its supervisor-usable bit is set, or, in user mode, its user-usable bit is set. Entry e occupies config addresses 16+4e+k. Word k=0 is [31:12] base page, [3] valid, [2] supervisor-usable, [1] user-usable. Word k=1 is [31:12] physical page, [7:4] wimg, [3] supervisor key, [2] user key, [1:0] pp. Word k=2 is [19:0] size in pages.
- R8: On a block hit, `res_ppn` = physical page + (page - base) and `res_attr` = {1,1,wimg,pp} of the winning entry.
- R9: On a block hit the key is the entry's supervisor key when `req_super` is 1, else its user key. Pass-through and memory-forced accesses use key 0.
- R10: A read violates only at key 1 with pp 00. A write violates at key 0 with pp 11, and at key 1 with pp 00, 01 or 11. A violation sets `res_status` to 0x08000000, ORed with 0x02000000 for a write, while `res_ppn` and `res_attr` still report the translation.
- R11: When translation is on, the segment has bit 31 clear and no usable entry covers the page, `res_walk` is 1 and `res_status` is 0x40000000, ORed with 0x02000000 for a write. `res_ppn` and `res_attr` are 0.
- R12: A request sampled with `req` high at a clock edge produces its results, with `res_valid` high, after the next edge. `res_valid` is high for one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| req | input | 1 | Request strobe |
| req_ea | input | 32 | Effective address |
| req_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_write | input | 1 | 1 = write access |
| req_super | input | 1 | 1 = supervisor mode |
| req_xlate_en | input | 1 | 1 = translation enabled |
| res_valid | output | 1 | Result valid, one cycle per request |
| res_ppn | output | 20 | Physical page number |
| res_attr | output | 8 | Referenced, changed, wimg, pp |
| res_walk | output | 1 | Hashed table walk required |
| res_dserr | output | 1 | Direct-store segment error |
| res_status | output | 32 | Fault status word |

## Verification
Every result of this block is due on the first clock edge after the one that samples `req`. The resolve path is purely combinational over the request and the stored configuration, and it feeds a single register stage. The bench changes inputs on the falling edge, holds `req` for exactly one rising edge, and reads all outputs at the following falling edge. At that point the single result register has just loaded. Configuration writes take effect at the edge that samples `cfg_we`, so each write completes before the next request is raised.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int EA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int PG_W    = EA_W - OFF_W;
  localparam int SEG_N   = 16;
  localparam int ATTR_W  = 8;

  localparam logic [31:0] ST_NOPAGE = 32'h4000_0000;
  localparam logic [31:0] ST_PROT   = 32'h0800_0000;
  localparam logic [31:0] ST_STORE  = 32'h0200_0000;
  localparam logic [8:0]  FORCED_ID = 9'h07F;
  localparam logic [1:0]  PASS_PP   = 2'b10;

  typedef struct packed {
    logic [PG_W-1:0] base;
    logic [PG_W-1:0] phys;
    logic [PG_W-1:0] size;
    logic            valid;
    logic            sup_ok;
    logic            usr_ok;
    logic            sup_key;
    logic            usr_key;
    logic [3:0]      wimg;
    logic [1:0]      pp;
  } blk_t;

  function automatic logic [ATTR_W-1:0] mk_attr(input logic [3:0] wimg, input logic [1:0] pp);
    return {2'b11, wimg, pp};
  endfunction

  function automatic logic covers(input logic [PG_W-1:0] page, input logic [PG_W-1:0] base,
                                  input logic [PG_W-1:0] size);
    logic [PG_W-1:0] off;
    off = page - base;
    return (page >= base) && (off < size);
  endfunction

  function automatic logic prot_bad(input logic wr, input logic key, input logic [1:0] pp);
    logic bad;
    case ({wr, key, pp})
      4'b0100: bad = 1'b1;
      4'b1011: bad = 1'b1;
      4'b1100: bad = 1'b1;
      4'b1101: bad = 1'b1;
      4'b1111: bad = 1'b1;
      default: bad = 1'b0;
    endcase
    return bad;
  endfunction
endpackage

// File: rtl/xlat_cfg_regs.sv
module xlat_cfg_regs
  import xlat_pkg::*;
#(
  parameter int BANK = 4,
  localparam int NBLK = 2 * BANK,
  localparam int CFG_AW = $clog2(SEG_N + 4 * NBLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       seg_q [SEG_N],
  output blk_t              blk_q [NBLK]
);
  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) seg_q[s] <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(s)) seg_q[s] <= cfg_wdata;
    end
  end

  for (genvar e = 0; e < NBLK; e++) begin : g_blk
    localparam int A0 = SEG_N + 4 * e;
    always_ff @(posedge clk) begin
      if (rst) begin
        blk_q[e] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == CFG_AW'(A0)) begin
          blk_q[e].base   <= cfg_wdata[31:12];
          blk_q[e].valid  <= cfg_wdata[3];
          blk_q[e].sup_ok <= cfg_wdata[2];
          blk_q[e].usr_ok <= cfg_wdata[1];
        end
        if (cfg_addr == CFG_AW'(A0 + 1)) begin
          blk_q[e].phys    <= cfg_wdata[31:12];
          blk_q[e].wimg    <= cfg_wdata[7:4];
          blk_q[e].sup_key <= cfg_wdata[3];
          blk_q[e].usr_key <= cfg_wdata[2];
          blk_q[e].pp      <= cfg_wdata[1:0];
        end
        if (cfg_addr == CFG_AW'(A0 + 2)) begin
          blk_q[e].size <= cfg_wdata[PG_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/xlat_blk_match.sv
module xlat_blk_match
  import xlat_pkg::*;
#(
  parameter int BANK = 4
) (
  input  logic              super_mode,
  input  logic [PG_W-1:0]   page,
  input  blk_t              bank [BANK],
  output logic              hit,
  output logic [BANK-1:0]   win_oh,
  output logic [PG_W-1:0]   ppn,
  output logic [ATTR_W-1:0] attr,
  output logic              key
);
  logic [BANK-1:0] cand;
  logic [PG_W-1:0] dest [BANK];

  for (genvar i = 0; i < BANK; i++) begin : g_ent
    logic usable;
    assign usable  = bank[i].valid && (super_mode ? bank[i].sup_ok : bank[i].usr_ok);
    assign cand[i] = usable && covers(page, bank[i].base, bank[i].size);
    assign dest[i] = bank[i].phys + (page - bank[i].base);
    if (i == 0) begin : g_first
      assign win_oh[i] = cand[i];
    end else begin : g_rest
      assign win_oh[i] = cand[i] && !(|cand[i-1:0]);
    end
  end

  assign hit = |cand;

  always_comb begin
    ppn  = '0;
    attr = '0;
    key  = 1'b0;
    for (int i = 0; i < BANK; i++) begin
      ppn  = ppn  | ({PG_W{win_oh[i]}} & dest[i]);
      attr = attr | ({ATTR_W{win_oh[i]}} & mk_attr(bank[i].wimg, bank[i].pp));
      key  = key  | (win_oh[i] & (super_mode ? bank[i].sup_key : bank[i].usr_key));
    end
  end
endmodule

// File: rtl/xlat_prot_check.sv
module xlat_prot_check
  import xlat_pkg::*;
(
  input  logic       granted,
  input  logic       wr,
  input  logic       key,
  input  logic [1:0] pp,
  output logic       violate
);
  assign violate = granted && prot_bad(wr, key, pp);
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int BANK = 4,
  localparam int NBLK = 2 * BANK,
  localparam int CFG_AW = $clog2(SEG_N + 4 * NBLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req,
  input  logic [EA_W-1:0]   req_ea,
  input  logic              req_data,
  input  logic              req_write,
  input  logic              req_super,
  input  logic              req_xlate_en,
  output logic              res_valid,
  output logic [PG_W-1:0]   res_ppn,
  output logic [ATTR_W-1:0] res_attr,
  output logic              res_walk,
  output logic              res_dserr,
  output logic [31:0]       res_status
);
  logic [31:0] seg_q [SEG_N];
  blk_t        blk_q [NBLK];
  blk_t        bank  [BANK];

  xlat_cfg_regs #(.BANK(BANK)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .seg_q(seg_q), .blk_q(blk_q)
  );

  always_comb begin
    for (int i = 0; i < BANK; i++) bank[i] = req_data ? blk_q[BANK + i] : blk_q[i];
  end

  logic [PG_W-1:0]   page;
  logic [31:0]       seg;
  logic              blk_hit;
  logic [BANK-1:0]   blk_win_oh;
  logic [PG_W-1:0]   blk_ppn;
  logic [ATTR_W-1:0] blk_attr;
  logic              blk_key;

  assign page = req_ea[EA_W-1:OFF_W];
  assign seg  = seg_q[req_ea[31:28]];

  xlat_blk_match #(.BANK(BANK)) u_match (
    .super_mode(req_super), .page(page), .bank(bank), .hit(blk_hit),
    .win_oh(blk_win_oh), .ppn(blk_ppn), .attr(blk_attr), .key(blk_key)
  );

  logic [PG_W-1:0]   nx_ppn;
  logic [ATTR_W-1:0] nx_attr;
  logic              nx_key;
  logic              nx_granted;
  logic              nx_walk;
  logic              nx_dserr;
  logic              prot_fail;
  logic [31:0]       nx_status;
  logic [31:0]       store_bit;

  always_comb begin
    nx_ppn     = '0;
    nx_attr    = '0;
    nx_key     = 1'b0;
    nx_granted = 1'b0;
    nx_walk    = 1'b0;
    nx_dserr   = 1'b0;
    if (!req_xlate_en) begin
      nx_ppn     = page;
      nx_attr    = mk_attr(4'b0000, PASS_PP);
      nx_granted = 1'b1;
    end else if (seg[31]) begin
      if (seg[28:20] == FORCED_ID) begin
        nx_ppn     = {seg[3:0], req_ea[27:12]};
        nx_attr    = mk_attr(4'b0000, PASS_PP);
        nx_granted = 1'b1;
      end else begin
        nx_dserr = 1'b1;
      end
    end else if (blk_hit) begin
      nx_ppn     = blk_ppn;
      nx_attr    = blk_attr;
      nx_key     = blk_key;
      nx_granted = 1'b1;
    end else begin
      nx_walk = 1'b1;
    end
  end

  xlat_prot_check u_prot (
    .granted(nx_granted), .wr(req_write), .key(nx_key),
    .pp(nx_attr[1:0]), .violate(prot_fail)
  );

  assign store_bit = req_write ? ST_STORE : 32'h0;
  assign nx_status = nx_walk   ? (ST_NOPAGE | store_bit) :
                     prot_fail ? (ST_PROT | store_bit)   : 32'h0;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_ppn    <= '0;
      res_attr   <= '0;
      res_walk   <= 1'b0;
      res_dserr  <= 1'b0;
      res_status <= '0;
    end else begin
      res_valid <= req;
      if (req) begin
        res_ppn    <= nx_ppn;
        res_attr   <= nx_attr;
        res_walk   <= nx_walk;
        res_dserr  <= nx_dserr;
        res_status <= nx_status;
      end
    end
  end
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
  parameter int BANK = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req,
  input logic [31:0]     req_ea,
  input logic            req_write,
  input logic            req_xlate_en,
  input logic            res_valid,
  input logic [19:0]     res_ppn,
  input logic [7:0]      res_attr,
  input logic            res_walk,
  input logic            res_dserr,
  input logic [31:0]     res_status,
  input logic [BANK-1:0] blk_win_oh
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !res_valid);

  a_r12_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    req |=> res_valid);

  a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !req |=> !res_valid);

  a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
    (req && !req_xlate_en) |=> (res_ppn == $past(req_ea[31:12])) && (res_attr == 8'hC2)
      && !res_walk && !res_dserr && (res_status == 32'h0));

  a_r4_dserr_clean: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_dserr) |-> !res_walk && (res_status == 32'h0) && (res_ppn == 20'h0));

  a_r11_walk_status: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_walk) |-> res_status[30] && !res_status[27] && !res_dserr);

  a_r10_store_bit_reads: assert property (@(posedge clk) disable iff (rst)
    (req && !req_write) |=> !res_status[25]);

  a_r6_single_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(blk_win_oh));
endmodule

bind xlat_unit xlat_unit_chk #(.BANK(BANK)) u_chk (
  .clk(clk), .rst(rst), .req(req), .req_ea(req_ea), .req_write(req_write),
  .req_xlate_en(req_xlate_en), .res_valid(res_valid), .res_ppn(res_ppn),
  .res_attr(res_attr), .res_walk(res_walk), .res_dserr(res_dserr),
  .res_status(res_status), .blk_win_oh(blk_win_oh)
);

// File: tb/tb_xlat_unit.sv
`timescale 1ns/1ps
module tb_xlat_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req = 1'b0;
  logic [31:0] req_ea = '0;
  logic        req_data = 1'b0, req_write = 1'b0, req_super = 1'b0, req_xlate_en = 1'b0;
  logic        res_valid, res_walk, res_dserr;
  logic [19:0] res_ppn;
  logic [7:0]  res_attr;
  logic [31:0] res_status;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  xlat_unit dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req(req), .req_ea(req_ea), .req_data(req_data), .req_write(req_write),
    .req_super(req_super), .req_xlate_en(req_xlate_en), .res_valid(res_valid),
    .res_ppn(res_ppn), .res_attr(res_attr), .res_walk(res_walk),
    .res_dserr(res_dserr), .res_status(res_status)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [31:0] ea;
    logic        data, wr, sup, xen;
    logic [19:0] ppn;
    logic [7:0]  attr;
    logic        walk, dserr;
    logic [31:0] st;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{4'd2,  32'h1234_5678, 1'b1,1'b1,1'b0,1'b0, 20'h12345, 8'hC2, 1'b0,1'b0, 32'h0},         // R2 write, off
    '{4'd13, 32'h2000_0000, 1'b0,1'b0,1'b1,1'b0, 20'h20000, 8'hC2, 1'b0,1'b0, 32'h0},         // R2 T ignored when off
    '{4'd3,  32'h1000_5000, 1'b1,1'b0,1'b1,1'b1, 20'hA0005, 8'hC2, 1'b0,1'b0, 32'h0},         // R3 forced
    '{4'd3,  32'h1FFF_F000, 1'b1,1'b1,1'b0,1'b1, 20'hAFFFF, 8'hC2, 1'b0,1'b0, 32'h0},         // R3 forced write
    '{4'd4,  32'h2000_0000, 1'b1,1'b0,1'b1,1'b1, 20'h0,     8'h00, 1'b0,1'b1, 32'h0},         // R4 dserr
    '{4'd6,  32'h0010_3ABC, 1'b0,1'b0,1'b1,1'b1, 20'h00803, 8'hD6, 1'b0,1'b0, 32'h0},         // R6 lowest wins, R8
    '{4'd6,  32'h0010_F000, 1'b0,1'b0,1'b1,1'b1, 20'h0080F, 8'hD6, 1'b0,1'b0, 32'h0},         // R6 last page
    '{4'd6,  32'h0012_0000, 1'b0,1'b0,1'b0,1'b1, 20'h00920, 8'hC2, 1'b0,1'b0, 32'h0},         // R6 second entry
    '{4'd6,  32'h000F_F000, 1'b0,1'b0,1'b1,1'b1, 20'h0,     8'h00, 1'b1,1'b0, 32'h4000_0000}, // R6 below base
    '{4'd8,  32'h0010_4000, 1'b1,1'b0,1'b1,1'b1, 20'h00A04, 8'hCD, 1'b0,1'b0, 32'h0},         // R8 data bank
    '{4'd10, 32'h0010_4000, 1'b1,1'b1,1'b1,1'b1, 20'h00A04, 8'hCD, 1'b0,1'b0, 32'h0},         // R10 k0 pp01 wr ok
    '{4'd7,  32'h0010_4000, 1'b1,1'b0,1'b0,1'b1, 20'h00B04, 8'hC3, 1'b0,1'b0, 32'h0},         // R7 user skips sup-only
    '{4'd10, 32'h0010_4000, 1'b1,1'b1,1'b0,1'b1, 20'h00B04, 8'hC3, 1'b0,1'b0, 32'h0A00_0000}, // R10 k1 pp11 wr
    '{4'd9,  32'h0020_5000, 1'b1,1'b0,1'b1,1'b1, 20'h00C05, 8'hFC, 1'b0,1'b0, 32'h0800_0000}, // R9 sup key1 pp00 rd
    '{4'd9,  32'h0020_5000, 1'b1,1'b0,1'b0,1'b1, 20'h00C05, 8'hFC, 1'b0,1'b0, 32'h0},         // R9 user key0
    '{4'd10, 32'h0020_5000, 1'b1,1'b1,1'b0,1'b1, 20'h00C05, 8'hFC, 1'b0,1'b0, 32'h0},         // R10 k0 pp00 wr ok
    '{4'd10, 32'h0020_5000, 1'b1,1'b1,1'b1,1'b1, 20'h00C05, 8'hFC, 1'b0,1'b0, 32'h0A00_0000}, // R10 k1 pp00 wr
    '{4'd10, 32'h0010_3000, 1'b0,1'b1,1'b0,1'b1, 20'h00803, 8'hD6, 1'b0,1'b0, 32'h0},         // R10 k1 pp10 wr ok
    '{4'd10, 32'h0040_0000, 1'b0,1'b1,1'b1,1'b1, 20'h00444, 8'hC3, 1'b0,1'b0, 32'h0A00_0000}, // R10 k0 pp11 wr
    '{4'd10, 32'h0050_0000, 1'b0,1'b1,1'b1,1'b1, 20'h00555, 8'hC1, 1'b0,1'b0, 32'h0A00_0000}, // R10 k1 pp01 wr
    '{4'd7,  32'h0030_0000, 1'b1,1'b0,1'b1,1'b1, 20'h0,     8'h00, 1'b1,1'b0, 32'h4000_0000}, // R7 invalid entry
    '{4'd11, 32'h0030_0000, 1'b1,1'b1,1'b1,1'b1, 20'h0,     8'h00, 1'b1,1'b0, 32'h4200_0000}, // R11 miss write
    '{4'd5,  32'h0020_5000, 1'b0,1'b0,1'b1,1'b1, 20'h0,     8'h00, 1'b1,1'b0, 32'h4000_0000}, // R5 instr bank only
    '{4'd11, 32'h0011_0000, 1'b1,1'b0,1'b1,1'b1, 20'h0,     8'h00, 1'b1,1'b0, 32'h4000_0000}  // R11 size edge miss
  };

  task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic blk_wr(input int e, input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] w2);
    cfg_wr(6'(16 + 4 * e), w0);
    cfg_wr(6'(16 + 4 * e + 1), w1);
    cfg_wr(6'(16 + 4 * e + 2), w2);
  endtask

  task automatic issue(input logic [31:0] ea, input logic d, input logic w,
                       input logic s, input logic x);
    @(negedge clk);
    req = 1'b1; req_ea = ea; req_data = d; req_write = w; req_super = s; req_xlate_en = x;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", 64'(res_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid low after reset", 64'(res_valid), 64'd0);
    issue(32'h0010_3000, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1 cleared entries give walk", 64'(res_walk), 64'd1);
    chk("R12 valid one cycle after req", 64'(res_valid), 64'd1);
    @(negedge clk);
    chk("R12 valid drops", 64'(res_valid), 64'd0);

    cfg_wr(6'd1, 32'h87F0_000A);
    cfg_wr(6'd2, 32'h8100_0000);
    blk_wr(0, 32'h0010_000E, 32'h0080_0056, 32'h10);
    blk_wr(1, 32'h0010_000E, 32'h0090_0002, 32'h100);
    blk_wr(2, 32'h0040_000E, 32'h0044_4007, 32'h1);
    blk_wr(3, 32'h0050_000E, 32'h0055_500D, 32'h1);
    blk_wr(4, 32'h0010_000C, 32'h00A0_0035, 32'h10);
    blk_wr(5, 32'h0010_000A, 32'h00B0_000F, 32'h20);
    blk_wr(6, 32'h0020_000E, 32'h00C0_00F8, 32'h10);
    blk_wr(7, 32'h0030_0006, 32'h00D0_0002, 32'h10);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("vec%0d R%0d", i, VT[i].rq);
      issue(VT[i].ea, VT[i].data, VT[i].wr, VT[i].sup, VT[i].xen);
      chk({tag, " valid"}, 64'(res_valid), 64'd1);
      chk({tag, " ppn"},   64'(res_ppn),   64'(VT[i].ppn));
      chk({tag, " attr"},  64'(res_attr),  64'(VT[i].attr));
      chk({tag, " walk"},  64'(res_walk),  64'(VT[i].walk));
      chk({tag, " dserr"}, 64'(res_dserr), 64'(VT[i].dserr));
      chk({tag, " status"}, 64'(res_status), 64'(VT[i].st));
    end

    // R12: back-to-back requests each yield their own result on the next edge
    @(negedge clk);
    req = 1'b1; req_ea = 32'h1234_5000; req_xlate_en = 1'b0; req_write = 1'b0;
    @(negedge clk);
    chk("R12 first of pair", 64'(res_ppn), 64'h12345);
    req_ea = 32'h5432_1000;
    @(negedge clk);
    req = 1'b0;
    chk("R12 second of pair", 64'(res_ppn), 64'h54321);

    // R1: reset mid-run clears the configured entries
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    issue(32'h0010_3000, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1 entries cleared by reset", 64'(res_walk), 64'd1);
    issue(32'h1000_5000, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R1 segment cleared by reset", 64'(res_dserr), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule